// File: doc/BRIEF.md
# Three-Port Lane Routing Controller

This block decides, for a single-lane three-port switch, which input drives each of the three outputs. Input C fans out through a one-to-two demultiplexer toward outputs A and B. Inputs A and B share a two-to-one multiplexer toward output C. A select bit and a dual-send bit set the normal routing. Three per-port loopback bits can each override the routing of one output, and three per-port enable bits can each force one output idle.

For every output the block registers a two-bit source code and a matching idle flag. Both are updated on every rising edge of the control clock. The analog path uses the idle flag to cut the output's tail current and let both legs float to the termination supply. The routing is a pure function of the inputs sampled at the previous edge, so software or pins can change any control bit at any time.

Top module: `lane_route_ctrl`

## Requirements
- R1: While reset is asserted (rstN low), every source code reads 2'b11 (idle) and every idle flag reads 1.
- R2: Output C's code is 2'b00 (input A) when selIn is 0 and 2'b01 (input B) when selIn is 1, unless port C is in loopback or disabled.
- R3: With dualSendIn 0 and neither A nor B in loopback, output A is 2'b10 (input C) only when selIn is 0, and output B is 2'b10 only when selIn is 1. The other output reads 2'b11 (idle).
- R4: With dualSendIn 1, each of outputs A and B that is not in loopback reads 2'b10 (input C), whatever selIn is.
- R5: loopEnIn[0] set makes output A read 2'b00 (input A).
- R6: loopEnIn[1] set makes output B read 2'b01 (input B).
- R7: loopEnIn[2] set makes output C read 2'b10 (input C).
- R8: A loopback on one port leaves the other ports on their normal routing. This holds for the demux leg too: while A is looped, B carries input C only if selIn or dualSendIn is 1, and while B is looped, A carries input C only if selIn is 0 or dualSendIn is 1.
- R9: outEnIn[p] at 0 forces output p to 2'b11 and its idle flag to 1, whatever the routing or loopback says.
- R10: idleOut[p] is 1 exactly when output p's code is 2'b11. Bit order is 0 = A, 1 = B, 2 = C.
- R11: The outputs show the inputs sampled at the previous rising clock edge. They hold steady between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Normal-path select (0: A side, 1: B side) |
| dualSendIn | input | 1 | Send input C to both A and B |
| loopEnIn | input | 3 | Per-port loopback enable, bit 0 = A, 1 = B, 2 = C |
| outEnIn | input | 3 | Per-port output enable, same bit order |
| srcSelA | output | 2 | Source code of output A (00 A, 01 B, 10 C, 11 idle) |
| srcSelB | output | 2 | Source code of output B |
| srcSelC | output | 2 | Source code of output C |
| idleOut | output | 3 | Per-port idle flag, same bit order |

## Verification
The block holds no state beyond its output registers, so a wrong decode shows up at a port one clock after the input pattern that triggers it. The bench sweeps all 256 combinations of the eight control bits. Any wrong leg, wrong override priority or mismatched idle flag is therefore exposed within one cycle of its pattern. A register that lags or leads is caught by sampling each output both just before and just after the edge that should load it.

// File: rtl/lane_route_pkg.sv
package lane_route_pkg;
  localparam int PORT_COUNT = 3;
  localparam int SRC_W      = 2;
  localparam int PORT_A     = 0;
  localparam int PORT_B     = 1;
  localparam int PORT_C     = 2;

  typedef enum logic [SRC_W-1:0] {
    SRC_A    = 2'b00,
    SRC_B    = 2'b01,
    SRC_C    = 2'b10,
    SRC_IDLE = 2'b11
  } srcSel_e;

  // Strobes from the decision logic to the register stage
  typedef struct packed {
    logic loopA;
    logic loopB;
    logic loopC;
    logic cToA;
    logic cToB;
    logic muxPickB;
  } routeStrobe_t;
endpackage

// File: rtl/lane_route_decode.sv
module lane_route_decode
  import lane_route_pkg::*;
(
  input  logic                  sel,
  input  logic                  dualSend,
  input  logic [PORT_COUNT-1:0] loopEn,
  output routeStrobe_t          strobe
);
  always_comb begin
    strobe.loopA    = loopEn[PORT_A];
    strobe.loopB    = loopEn[PORT_B];
    strobe.loopC    = loopEn[PORT_C];
    // Demux legs: each leg is driven from C only when its own port is not looped
    strobe.cToA     = !loopEn[PORT_A] && (!sel || dualSend);
    strobe.cToB     = !loopEn[PORT_B] && (sel || dualSend);
    strobe.muxPickB = sel;
  end
endmodule

// File: rtl/lane_route_regs.sv
module lane_route_regs
  import lane_route_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  routeStrobe_t                strobe,
  input  logic [PORT_COUNT-1:0]       outEn,
  output logic [PORT_COUNT*SRC_W-1:0] srcBus,
  output logic [PORT_COUNT-1:0]       idleFlag
);
  srcSel_e rawSel [PORT_COUNT];

  always_comb begin
    if (strobe.loopA)     rawSel[PORT_A] = SRC_A;
    else if (strobe.cToA) rawSel[PORT_A] = SRC_C;
    else                  rawSel[PORT_A] = SRC_IDLE;

    if (strobe.loopB)     rawSel[PORT_B] = SRC_B;
    else if (strobe.cToB) rawSel[PORT_B] = SRC_C;
    else                  rawSel[PORT_B] = SRC_IDLE;

    if (strobe.loopC)         rawSel[PORT_C] = SRC_C;
    else if (strobe.muxPickB) rawSel[PORT_C] = SRC_B;
    else                      rawSel[PORT_C] = SRC_A;
  end

  for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
    srcSel_e gatedSel;
    srcSel_e selQ;
    logic    idleQ;

    assign gatedSel = outEn[p] ? rawSel[p] : SRC_IDLE;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        selQ  <= SRC_IDLE;
        idleQ <= 1'b1;
      end else begin
        selQ  <= gatedSel;
        idleQ <= (gatedSel == SRC_IDLE);
      end
    end

    assign srcBus[p*SRC_W +: SRC_W] = selQ;
    assign idleFlag[p]              = idleQ;
  end
endmodule

// File: rtl/lane_route_ctrl.sv
module lane_route_ctrl
  import lane_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selIn,
  input  logic       dualSendIn,
  input  logic [2:0] loopEnIn,
  input  logic [2:0] outEnIn,
  output logic [1:0] srcSelA,
  output logic [1:0] srcSelB,
  output logic [1:0] srcSelC,
  output logic [2:0] idleOut
);
  routeStrobe_t                  strobe;
  logic [PORT_COUNT*SRC_W-1:0]   srcBus;

  lane_route_decode u_decode (
    .sel      (selIn),
    .dualSend (dualSendIn),
    .loopEn   (loopEnIn),
    .strobe   (strobe)
  );

  lane_route_regs u_regs (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .outEn    (outEnIn),
    .srcBus   (srcBus),
    .idleFlag (idleOut)
  );

  assign srcSelA = srcBus[PORT_A*SRC_W +: SRC_W];
  assign srcSelB = srcBus[PORT_B*SRC_W +: SRC_W];
  assign srcSelC = srcBus[PORT_C*SRC_W +: SRC_W];
endmodule

// File: rtl/lane_route_chk.sv
module lane_route_chk (
  input logic       clk,
  input logic       rstN,
  input logic       selIn,
  input logic       dualSendIn,
  input logic [2:0] loopEnIn,
  input logic [2:0] outEnIn,
  input logic [1:0] srcSelA,
  input logic [1:0] srcSelB,
  input logic [1:0] srcSelC,
  input logic [2:0] idleOut
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rstN |=> (srcSelA == 2'b11 && srcSelB == 2'b11 && srcSelC == 2'b11 && idleOut == 3'b111));

  a_r2_mux_c: assert property (@(posedge clk) disable iff (!rstN)
    (!loopEnIn[2] && outEnIn[2]) |=> (srcSelC == {1'b0, $past(selIn)}));

  a_r4_dual_send: assert property (@(posedge clk) disable iff (!rstN)
    (dualSendIn && loopEnIn[1:0] == 2'b00 && outEnIn[1:0] == 2'b11)
      |=> (srcSelA == 2'b10 && srcSelB == 2'b10));

  a_r5_loop_a: assert property (@(posedge clk) disable iff (!rstN)
    (loopEnIn[0] && outEnIn[0]) |=> (srcSelA == 2'b00));

  a_r6_loop_b: assert property (@(posedge clk) disable iff (!rstN)
    (loopEnIn[1] && outEnIn[1]) |=> (srcSelB == 2'b01));

  a_r7_loop_c: assert property (@(posedge clk) disable iff (!rstN)
    (loopEnIn[2] && outEnIn[2]) |=> (srcSelC == 2'b10));

  a_r9_disable_a: assert property (@(posedge clk) disable iff (!rstN)
    !outEnIn[0] |=> (srcSelA == 2'b11 && idleOut[0]));

  a_r9_disable_c: assert property (@(posedge clk) disable iff (!rstN)
    !outEnIn[2] |=> (srcSelC == 2'b11 && idleOut[2]));

  a_r10_idle_flags: assert property (@(posedge clk) disable iff (!rstN)
    idleOut == {srcSelC == 2'b11, srcSelB == 2'b11, srcSelA == 2'b11});

  a_r3_legs_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    (!dualSendIn && loopEnIn[1:0] == 2'b00) |=> !(srcSelA == 2'b10 && srcSelB == 2'b10));
endmodule

bind lane_route_ctrl lane_route_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .selIn      (selIn),
  .dualSendIn (dualSendIn),
  .loopEnIn   (loopEnIn),
  .outEnIn    (outEnIn),
  .srcSelA    (srcSelA),
  .srcSelB    (srcSelB),
  .srcSelC    (srcSelC),
  .idleOut    (idleOut)
);

// File: tb/test_lane_route_ctrl.sv
`timescale 1ns/1ps
module test_lane_route_ctrl;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       selIn = 1'b0;
  logic       dualSendIn = 1'b0;
  logic [2:0] loopEnIn = 3'b000;
  logic [2:0] outEnIn = 3'b111;
  logic [1:0] srcSelA, srcSelB, srcSelC;
  logic [2:0] idleOut;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  lane_route_ctrl i_lane_route_ctrl (
    .clk(clk), .rstN(rstN), .selIn(selIn), .dualSendIn(dualSendIn),
    .loopEnIn(loopEnIn), .outEnIn(outEnIn),
    .srcSelA(srcSelA), .srcSelB(srcSelB), .srcSelC(srcSelC), .idleOut(idleOut)
  );

  function automatic logic [1:0] expCode(int p, logic s, logic d, logic [2:0] lp, logic [2:0] en);
    if (!en[p]) return 2'b11;
    if (lp[p]) return (p == 0) ? 2'b00 : (p == 1) ? 2'b01 : 2'b10;
    if (p == 2) return s ? 2'b01 : 2'b00;
    if (p == 0) return (!s || d) ? 2'b10 : 2'b11;
    return (s || d) ? 2'b10 : 2'b11;
  endfunction

  function automatic string tagFor(int p, logic d, logic [2:0] lp, logic [2:0] en);
    if (!en[p]) return "R9";
    if (lp[p]) return (p == 0) ? "R5" : (p == 1) ? "R6" : "R7";
    if (lp != 3'b000) return "R8";
    if (p == 2) return "R2";
    return d ? "R4" : "R3";
  endfunction

  task automatic check(string tag, string what, logic [3:0] act, logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [1:0] codeOf(int p);
    return (p == 0) ? srcSelA : (p == 1) ? srcSelB : srcSelC;
  endfunction

  initial begin
    #400000;
    mismatched++;
    $display("FAIL watchdog R11 actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [1:0] prevExp [3];
    logic [2:0] prevIdle;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1", "srcA", {2'b0, srcSelA}, 4'h3);
    check("R1", "srcB", {2'b0, srcSelB}, 4'h3);
    check("R1", "srcC", {2'b0, srcSelC}, 4'h3);
    check("R1", "idle", {1'b0, idleOut}, 4'h7);
    for (int k = 0; k < 3; k++) prevExp[k] = 2'b11;
    prevIdle = 3'b111;
    rstN = 1'b1;
    for (int v = 0; v < 256; v++) begin
      logic [1:0] e [3];
      logic [2:0] eIdle;
      selIn      = v[0];
      dualSendIn = v[1];
      loopEnIn   = v[4:2];
      outEnIn    = v[7:5];
      #1;
      // R11: outputs still hold the previous pattern before the edge
      for (int p = 0; p < 3; p++)
        check("R11", "hold", {2'b0, codeOf(p)}, {2'b0, prevExp[p]});
      check("R11", "holdIdle", {1'b0, idleOut}, {1'b0, prevIdle});
      @(posedge clk);
      @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        e[p] = expCode(p, selIn, dualSendIn, loopEnIn, outEnIn);
        eIdle[p] = (e[p] == 2'b11);
        check(tagFor(p, dualSendIn, loopEnIn, outEnIn), "code", {2'b0, codeOf(p)}, {2'b0, e[p]});
      end
      check("R10", "idle", {1'b0, idleOut}, {1'b0, eIdle});
      for (int p = 0; p < 3; p++) prevExp[p] = e[p];
      prevIdle = eIdle;
    end
    // R1 again: reset mid-run returns to idle
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "reResetC", {2'b0, srcSelC}, 4'h3);
    check("R1", "reResetIdle", {1'b0, idleOut}, 4'h7);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule